// File: doc/BRIEF.md
# Nine-Bit Serial Link Node with Address Filtering

This block is one full-duplex serial node for a shared multi-drop link. Each character on the wire takes eleven bit times: a low start bit, eight data bits sent least significant bit first, a ninth bit chosen by software, and a high stop bit. Software starts a transmission by strobing a byte into the transmit data input. The ninth bit comes from a control input, so it can carry a parity value or mark the character as an address.

On the receive side, the line is oversampled by a baud tick input running at sixteen times the bit rate. A falling edge on the idle-high line is confirmed at the middle of the start bit, and each later bit is decided by a majority of three samples near its centre. A finished character is kept only when the receive-done flag is clear. When address filtering is on, the ninth bit must also be 1. That way a node ignores data characters meant for other nodes and wakes only on address characters. Both done flags stay set until cleared by a strobe, and they feed one interrupt output that is gated by an enable. The bit-rate divider, the register interface and any queueing are outside this block.

Top module: `uart9_node`

## Requirements
- R1: A transmitted character drives, in order: start bit 0, data bits 0 through 7, the ninth bit taken from `tx_bit9` at the write, then stop bit 1. Each bit lasts 16 baud ticks.
- R2: While no character is in flight, `tx_line` is 1. A `tx_wr` pulse while idle starts a character.
- R3: `tx_done` goes to 1 on the tick where the stop bit starts, which is ten bit times after the start bit begins. It does not wait for the end of the stop bit.
- R4: A `tx_wr` pulse while a character is in flight is dropped and sends nothing. It sets `tx_collide`, which stays 1 until `clr_collide` is pulsed.
- R5: While `rx_en` is 0, nothing is received, and `rx_done`, `rx_data` and `rx_bit9` do not change.
- R6: The level sampled for the received stop bit has no effect on whether the character is kept.
- R7: A received character is stored in `rx_data`/`rx_bit9`, and `rx_done` is set, only if `rx_done` was 0. Otherwise all three keep their old values.
- R8: With `addr_filt_en` at 1, a character whose ninth bit is 0 is dropped and leaves `rx_done`, `rx_data` and `rx_bit9` unchanged. With `addr_filt_en` at 0, the ninth bit does not affect acceptance.
- R9: `irq` equals `irq_en` AND (`tx_done` OR `rx_done`).
- R10: `tx_done` and `rx_done` stay at 1 until their clear strobe. A set event in the same cycle as a clear wins.
- R11: A low pulse that is no longer high than half a bit at the start-bit check is treated as a false start and produces no character.
- R12: A single wrong oversample inside a bit is outvoted by the other two samples around the bit centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit for the next transmitted character |
| rx_en | input | 1 | Receive enable |
| addr_filt_en | input | 1 | Keep only characters whose ninth bit is 1 |
| irq_en | input | 1 | Interrupt enable |
| clr_tx_done | input | 1 | Clears `tx_done` |
| clr_rx_done | input | 1 | Clears `rx_done` |
| clr_collide | input | 1 | Clears `tx_collide` |
| rx_line | input | 1 | Serial input, idle high |
| tx_line | output | 1 | Serial output, idle high |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted character |
| tx_collide | output | 1 | Sticky flag for a dropped write during transmission |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach from the ports are the acceptance rule's rejection paths and the oversampling corner cases, because each needs a whole character placed with exact timing on `rx_line`. The bench drives characters at the bit level. It leaves `rx_done` set on purpose before a second character, so the old-data path is exercised. It sends a ninth bit of 0 with filtering on, a stop bit of 0, and an isolated short low pulse as a false start. It also flips one oversample with a 4-cycle glitch in the middle of a data bit. After each dropped character, the held byte and flags are read at the ports.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  // two of three samples decide the bit
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // keep a character only if the previous one was taken and the filter agrees
  function automatic logic accept_frame(input logic done_now, input logic filt, input logic bit9);
    return !done_now && (!filt || bit9);
  endfunction

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  output logic              line,
  output logic              busy,
  output logic              stop_begin,
  output logic              wr_reject
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] IDX_B9   = IDX_W'(FRAME_W - 2);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic               bit_end;

  assign bit_end = busy && baud_tick && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      busy  <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
    end else if (wr_stb && !busy) begin
      shreg <= {1'b1, wr_bit9, wr_data, 1'b0};
      busy  <= 1'b1;
      cnt   <= '0;
      idx   <= '0;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        cnt <= '0;
        if (idx == IDX_STOP) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign line       = busy ? shreg[0] : 1'b1;
  assign stop_begin = bit_end && (idx == IDX_B9);
  assign wr_reject  = wr_stb && busy;

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              enable,
  input  logic              line_in,
  output logic              frame_end,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_bit9
);
  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int NBITS = DATA_W + 1;
  localparam int IDX_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(NBITS);

  logic [1:0]        sync;
  logic              s;
  logic              prev_s;
  logic [1:0]        hist;
  logic              voted;
  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W:0]   shreg;
  logic              bit_end;

  assign s       = sync[1];
  assign voted   = maj3(hist[1], hist[0], s);
  assign bit_end = baud_tick && (state == RX_BITS) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      prev_s <= 1'b1;
      hist   <= 2'b11;
    end else begin
      sync <= {sync[0], line_in};
      if (baud_tick) begin
        prev_s <= s;
        hist   <= {hist[0], s};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (baud_tick) begin
      case (state)
        RX_IDLE: begin
          if (prev_s && !s) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == CNT_HALF) begin
            cnt <= '0;
            idx <= '0;
            state <= s ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (idx == IDX_STOP) begin
              state <= RX_IDLE;
            end else begin
              shreg <= {voted, shreg[DATA_W:1]};
              idx   <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign frame_end  = bit_end && (idx == IDX_STOP);
  assign frame_data = shreg[DATA_W-1:0];
  assign frame_bit9 = shreg[DATA_W];

endmodule

// File: rtl/uart9_flags.sv
module uart9_flags
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_stop_begin,
  input  logic              tx_wr_reject,
  input  logic              rx_frame_end,
  input  logic [DATA_W-1:0] rx_frame_data,
  input  logic              rx_frame_bit9,
  input  logic              filt_en,
  input  logic              irq_en,
  input  logic              clr_tx,
  input  logic              clr_rx,
  input  logic              clr_ovr,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              ovr,
  output logic              irq,
  output logic              rx_accept
);
  assign rx_accept = rx_frame_end && accept_frame(rx_done, filt_en, rx_frame_bit9);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (tx_stop_begin)     tx_done <= 1'b1;
      else if (clr_tx)       tx_done <= 1'b0;
      if (rx_accept) begin
        rx_done <= 1'b1;
        rx_data <= rx_frame_data;
        rx_bit9 <= rx_frame_bit9;
      end else if (clr_rx) begin
        rx_done <= 1'b0;
      end
      if (tx_wr_reject)      ovr <= 1'b1;
      else if (clr_ovr)      ovr <= 1'b0;
    end
  end

  assign irq = irq_en && (tx_done || rx_done);

endmodule

// File: rtl/uart9_node.sv
module uart9_node #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_bit9,
  input  logic              rx_en,
  input  logic              addr_filt_en,
  input  logic              irq_en,
  input  logic              clr_tx_done,
  input  logic              clr_rx_done,
  input  logic              clr_collide,
  input  logic              rx_line,
  output logic              tx_line,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              tx_collide,
  output logic              irq
);
  // internal events, named for the checker
  logic              tx_busy;
  logic              tx_stop_begin;
  logic              tx_wr_reject;
  logic              rx_frame_end;
  logic [DATA_W-1:0] rx_frame_data;
  logic              rx_frame_bit9;
  logic              rx_accept;

  uart9_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .wr_stb     (tx_wr),
    .wr_data    (tx_data),
    .wr_bit9    (tx_bit9),
    .line       (tx_line),
    .busy       (tx_busy),
    .stop_begin (tx_stop_begin),
    .wr_reject  (tx_wr_reject)
  );

  uart9_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .enable     (rx_en),
    .line_in    (rx_line),
    .frame_end  (rx_frame_end),
    .frame_data (rx_frame_data),
    .frame_bit9 (rx_frame_bit9)
  );

  uart9_flags #(.DATA_W(DATA_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_stop_begin (tx_stop_begin),
    .tx_wr_reject  (tx_wr_reject),
    .rx_frame_end  (rx_frame_end),
    .rx_frame_data (rx_frame_data),
    .rx_frame_bit9 (rx_frame_bit9),
    .filt_en       (addr_filt_en),
    .irq_en        (irq_en),
    .clr_tx        (clr_tx_done),
    .clr_rx        (clr_rx_done),
    .clr_ovr       (clr_collide),
    .tx_done       (tx_done),
    .rx_done       (rx_done),
    .rx_data       (rx_data),
    .rx_bit9       (rx_bit9),
    .ovr           (tx_collide),
    .irq           (irq),
    .rx_accept     (rx_accept)
  );

endmodule

// File: rtl/uart9_node_chk.sv
module uart9_node_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_wr,
  input logic              rx_en,
  input logic              addr_filt_en,
  input logic              clr_tx_done,
  input logic              clr_rx_done,
  input logic              tx_line,
  input logic              tx_done,
  input logic              rx_done,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_collide,
  input logic              irq,
  input logic              tx_busy,
  input logic              tx_stop_begin,
  input logic              rx_frame_end,
  input logic              rx_frame_bit9
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  assert_done_at_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_begin |=> (tx_done && tx_line && tx_busy));

  assert_busy_write_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_busy) |=> tx_collide);

  assert_rx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_frame_end);

  assert_reject_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_end && rx_done && !clr_rx_done) |=> (rx_done && $stable(rx_data)));

  assert_filter_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_end && addr_filt_en && !rx_frame_bit9 && !rx_done) |=> (!rx_done && $stable(rx_data)));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (tx_done || rx_done));

  assert_tx_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !clr_tx_done) |=> tx_done);

endmodule

bind uart9_node uart9_node_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_wr         (tx_wr),
  .rx_en         (rx_en),
  .addr_filt_en  (addr_filt_en),
  .clr_tx_done   (clr_tx_done),
  .clr_rx_done   (clr_rx_done),
  .tx_line       (tx_line),
  .tx_done       (tx_done),
  .rx_done       (rx_done),
  .rx_data       (rx_data),
  .tx_collide    (tx_collide),
  .irq           (irq),
  .tx_busy       (tx_busy),
  .tx_stop_begin (tx_stop_begin),
  .rx_frame_end  (rx_frame_end),
  .rx_frame_bit9 (rx_frame_bit9)
);

// File: tb/uart9_node_test.sv
`timescale 1ns/1ps
module uart9_node_test;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick;
  logic tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_bit9 = 1'b0;
  logic rx_en = 1'b0, addr_filt_en = 1'b0, irq_en = 1'b0;
  logic clr_tx_done = 1'b0, clr_rx_done = 1'b0, clr_collide = 1'b0;
  logic rx_line = 1'b1;
  logic tx_line, tx_done, rx_done, rx_bit9, tx_collide, irq;
  logic [7:0] rx_data;

  int total = 0;
  int bad = 0;
  logic [8:0] tx_q[$];
  logic [8:0] rx_q[$];
  int div_cnt = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) div_cnt <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
  assign baud_tick = (div_cnt == TICK_DIV - 1);

  uart9_node uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9),
    .rx_en(rx_en), .addr_filt_en(addr_filt_en), .irq_en(irq_en),
    .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done), .clr_collide(clr_collide),
    .rx_line(rx_line), .tx_line(tx_line), .tx_done(tx_done), .rx_done(rx_done),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .tx_collide(tx_collide), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  // driver: a write, with the expected character pushed when it should go out
  task automatic do_write(input logic [7:0] d, input logic b9, input bit expect_sent);
    @(negedge clk);
    tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
    if (expect_sent) tx_q.push_back({b9, d});
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  // bit-level drive of one character on rx_line
  task automatic send_rx(input logic [7:0] d, input logic b9, input logic stp,
                         input int glitch_idx, input bit expect_kept);
    logic [10:0] f;
    f = {stp, b9, d, 1'b0};
    if (expect_kept) rx_q.push_back({b9, d});
    for (int i = 0; i < 11; i++) begin
      for (int c = 0; c < BIT_CLK; c++) begin
        @(negedge clk);
        rx_line = (glitch_idx == i && c >= 30 && c < 34) ? ~f[i] : f[i];
      end
    end
    @(negedge clk); rx_line = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  // transmit monitor: decode tx_line at bit centres and compare with the queue
  initial begin
    logic [10:0] got;
    logic [8:0] exp;
    forever begin
      @(negedge tx_line);
      repeat (BIT_CLK / 2) @(negedge clk);
      for (int i = 0; i < 11; i++) begin
        got[i] = tx_line;
        if (i < 10) repeat (BIT_CLK) @(negedge clk);
      end
      if (tx_q.size() == 0) begin
        check(1'b0, "R4 unexpected tx character", {21'd0, got}, 32'd0);
      end else begin
        exp = tx_q.pop_front();
        check(got == {1'b1, exp, 1'b0}, "R1 tx frame bits", {21'd0, got}, {21'd0, 1'b1, exp, 1'b0});
      end
    end
  end

  // R3: clocks from start-bit edge to tx_done
  initial begin
    int n;
    forever begin
      @(negedge tx_line);
      n = 0;
      while (!tx_done && n < 2000) begin
        @(negedge clk);
        n++;
      end
      check(n >= 10 * BIT_CLK - TICK_DIV - 2 && n <= 10 * BIT_CLK + 2,
            "R3 tx_done at stop start", n, 10 * BIT_CLK);
      check(tx_line == 1'b1, "R3 line high when tx_done sets", {31'd0, tx_line}, 1);
    end
  end

  // receive monitor: each rise of rx_done must match the oldest expected character
  initial begin
    logic prev;
    logic [8:0] exp;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_done && !prev) begin
        if (rx_q.size() == 0) begin
          check(1'b0, "R7 unexpected rx character", {23'd0, rx_bit9, rx_data}, 32'd0);
        end else begin
          exp = rx_q.pop_front();
          check({rx_bit9, rx_data} == exp, "R7 rx character stored",
                {23'd0, rx_bit9, rx_data}, {23'd0, exp});
        end
      end
      prev = rx_done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 0);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    // reset state
    check(tx_line == 1'b1, "R2 idle line after reset", {31'd0, tx_line}, 1);
    check(tx_done == 1'b0 && rx_done == 1'b0, "R10 flags clear in reset", {30'd0, tx_done, rx_done}, 0);
    check(irq == 1'b0 && tx_collide == 1'b0, "R9 irq and R4 collide low in reset", {30'd0, irq, tx_collide}, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (10) @(negedge clk);

    // transmit, irq gated off
    do_write(8'hA5, 1'b1, 1'b1);
    repeat (11 * BIT_CLK + 40) @(negedge clk);
    check(tx_done == 1'b1, "R10 tx_done held after frame", {31'd0, tx_done}, 1);
    check(irq == 1'b0, "R9 irq masked", {31'd0, irq}, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R9 irq from tx_done", {31'd0, irq}, 1);
    pulse(clr_tx_done);
    check(tx_done == 1'b0 && irq == 1'b0, "R10 tx_done cleared by strobe", {30'd0, tx_done, irq}, 0);

    // write during flight is dropped
    do_write(8'h3C, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    do_write(8'hFF, 1'b1, 1'b0);
    check(tx_collide == 1'b1, "R4 collide set", {31'd0, tx_collide}, 1);
    repeat (2 * 11 * BIT_CLK) @(negedge clk);
    check(tx_q.size() == 0, "R4 only one character sent", tx_q.size(), 0);
    check(tx_collide == 1'b1, "R4 collide sticky", {31'd0, tx_collide}, 1);
    pulse(clr_collide);
    check(tx_collide == 1'b0, "R4 collide cleared", {31'd0, tx_collide}, 0);
    pulse(clr_tx_done);

    // receive, filter off, ninth bit 0 accepted
    send_rx(8'h5A, 1'b0, 1'b1, -1, 1'b1);
    check(rx_done == 1'b1 && irq == 1'b1, "R8 kept with filter off, R9 irq", {30'd0, rx_done, irq}, 3);
    // second character while rx_done still set is dropped
    send_rx(8'h11, 1'b1, 1'b1, -1, 1'b0);
    check({rx_bit9, rx_data} == 9'h05A, "R7 old character held", {23'd0, rx_bit9, rx_data}, 32'h05A);
    pulse(clr_rx_done);
    check(rx_done == 1'b0, "R10 rx_done cleared", {31'd0, rx_done}, 0);

    // filter on
    addr_filt_en = 1'b1;
    send_rx(8'h22, 1'b0, 1'b1, -1, 1'b0);
    check(rx_done == 1'b0 && {rx_bit9, rx_data} == 9'h05A, "R8 data character dropped",
          {22'd0, rx_done, rx_bit9, rx_data}, 32'h05A);
    send_rx(8'h77, 1'b1, 1'b1, -1, 1'b1);
    check(rx_done == 1'b1 && rx_bit9 == 1'b1, "R8 address character kept", {30'd0, rx_done, rx_bit9}, 3);
    pulse(clr_rx_done);

    // stop bit low is ignored
    send_rx(8'hC3, 1'b1, 1'b0, -1, 1'b1);
    check(rx_done == 1'b1, "R6 stop bit level ignored", {31'd0, rx_done}, 1);
    pulse(clr_rx_done);
    repeat (40) @(negedge clk);

    // receiver disabled
    rx_en = 1'b0;
    send_rx(8'h44, 1'b1, 1'b1, -1, 1'b0);
    check(rx_done == 1'b0 && rx_data == 8'hC3, "R5 nothing received when disabled",
          {23'd0, rx_done, rx_data}, 32'h0C3);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);

    // false start
    @(negedge clk); rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check(rx_done == 1'b0, "R11 short low pulse rejected", {31'd0, rx_done}, 0);
    send_rx(8'h99, 1'b1, 1'b1, -1, 1'b1);
    check(rx_done == 1'b1, "R11 real start after false start", {31'd0, rx_done}, 1);
    pulse(clr_rx_done);

    // one bad sample inside data bit 0 (frame index 1) is outvoted
    send_rx(8'h0F, 1'b1, 1'b1, 1, 1'b1);
    check(rx_done == 1'b1 && rx_data == 8'h0F, "R12 majority vote", {23'd0, rx_done, rx_data}, 32'h10F);
    pulse(clr_rx_done);

    repeat (20) @(negedge clk);
    check(rx_q.size() == 0 && tx_q.size() == 0, "R7 all expected characters seen",
          rx_q.size() + tx_q.size(), 0);
    summary();
  end

endmodule